// File: doc/BRIEF.md
# Serial Transmitter with CTS Hold-off

This block turns bytes into asynchronous serial frames. Software, or any producer, pushes bytes into a small queue. The block takes them out one at a time. Each frame starts with a low start bit, then 5 to 8 data bits, an optional parity bit and one or two high stop bits. Every bit lasts sixteen pulses of an oversampling tick, which a separate baud generator supplies.

Frame format, queue mode, break, loopback and flow control come from static configuration inputs. The bit positions of those inputs follow the line-control layout that the matching receiver also decodes.

The block has an optional hold-off. When it is on, a new frame starts only while the clear-to-send input is active. The active level of that input is programmable. A frame that has already started always runs to its last stop bit. A status byte reports queue empty, queue full and busy. An interrupt output is raised when the queue is empty and the interrupt is enabled.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, `txd` and `loop_txd` are high, `flags` reads 8'h80 (queue empty, not full, not busy), and `tx_irq` follows `tx_irq_en`.
- R2: A frame is a low start bit, then the data bits least significant first, then the stop bits. Each bit is held for exactly 16 `tick16` pulses. The data length is 5 + `lcr[6:5]` bits (00=5, 01=6, 10=7, 11=8).
- R3: When `lcr[1]` is set, a parity bit follows the data. With `lcr[2]` set, parity is even (the data ones plus the parity bit make an even count). With `lcr[2]` clear, parity is odd.
- R4: `lcr[3]` selects two stop bits; when it is clear, one stop bit is sent.
- R5: While `lcr[0]` is set, the transmitted line is driven low. Frame timing keeps running underneath the break.
- R6: With `lcr[4]` set the queue holds 16 bytes; with it clear the queue holds 1 byte. A write while the queue is full is dropped. `flags[7]` is queue empty and `flags[5]` is queue full.
- R7: `flags[3]` (busy) is set while any byte is queued or being sent. It clears only when the last stop bit of the last frame has ended.
- R8: When `auto_flow` and `cts_gate` are both set, a new frame starts only on a tick where CTS is active. CTS is active when `cts_in` equals `cts_pol`. A frame in progress always completes. With either control clear, CTS is ignored.
- R9: `tx_irq` is high exactly while `tx_irq_en` is set and the queue is empty.
- R10: With `loopback` set, `txd` stays high and the serial stream, including any break, appears on `loop_txd`. With `loopback` clear, `loop_txd` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling pulse, 16 per bit time |
| cts_in | input | 1 | Clear-to-send input |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to send |
| lcr | input | 7 | Line control: [0] break, [1] parity enable, [2] even parity, [3] two stop bits, [4] 16-deep queue, [6:5] length code |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| loopback | input | 1 | Route the stream to `loop_txd` and hold `txd` high |
| auto_flow | input | 1 | Automatic flow-control enable |
| cts_gate | input | 1 | Let CTS gate frame starts |
| cts_pol | input | 1 | Level of `cts_in` that counts as active |
| txd | output | 1 | Serial output |
| loop_txd | output | 1 | Internal loopback stream |
| tx_irq | output | 1 | Transmit interrupt |
| flags | output | 8 | [7] empty, [5] full, [3] busy, other bits zero |

## Verification
The hardest case to reach is CTS going inactive in the middle of a frame while more bytes are still queued. The frame on the wire must finish intact, and the next frame must not start, even though busy stays set.

The stimulus waits until the reference model shows the fifth bit of a frame on the line, with two more bytes queued. At that point it drops CTS. It then waits well beyond one frame time to confirm that the line idles high and the flags read busy-but-not-empty. Finally it reactivates CTS by flipping the polarity control rather than the pin, which also exercises the polarity setting.

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
  parameter int DEPTH = 16,
  parameter int SUB   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       cts_in,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [6:0] lcr,
  input  logic       tx_irq_en,
  input  logic       loopback,
  input  logic       auto_flow,
  input  logic       cts_gate,
  input  logic       cts_pol,
  output logic       txd,
  output logic       loop_txd,
  output logic       tx_irq,
  output logic [7:0] flags
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(SUB);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          active;
  logic [11:0]   sh;
  logic [3:0]    left;
  logic [SW-1:0] sub;
  logic [11:0]   nf;
  logic [3:0]    nlen, dlen;
  logic          par;

  wire [CW-1:0] cap     = lcr[4] ? CW'(DEPTH) : CW'(1);
  wire          full    = cnt >= cap;
  wire          empty   = cnt == '0;
  wire          cts_ok  = !(auto_flow && cts_gate) || (cts_in == cts_pol);
  wire          bit_end = active && tick16 && (sub == SW'(SUB - 1));
  wire          last    = bit_end && (left == 4'd1);
  wire          load    = tick16 && (!active || last) && !empty && cts_ok;
  wire          push    = wr_en && !full;
  wire          busy    = active || !empty;

  always_comb begin
    dlen  = 4'd5 + {2'b00, lcr[6:5]};
    nlen  = 4'd2 + dlen + {3'b000, lcr[1]} + {3'b000, lcr[3]};
    par   = ~lcr[2];
    nf    = '1;
    nf[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(dlen)) begin
        nf[i+1] = mem[rp][i];
        par     = par ^ mem[rp][i];
      end
    end
    for (int i = 6; i < 10; i++)
      if (lcr[1] && i == int'(dlen) + 1) nf[i] = par;
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      active <= 1'b0;
      sh     <= '1;
      left   <= '0;
      sub    <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(load);
      if (load) begin
        rp     <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
        active <= 1'b1;
        sh     <= nf;
        left   <= nlen;
        sub    <= '0;
      end else if (last) begin
        active <= 1'b0;
        sub    <= '0;
      end else if (bit_end) begin
        sh   <= {1'b1, sh[11:1]};
        left <= left - 4'd1;
        sub  <= '0;
      end else if (active && tick16) begin
        sub <= sub + SW'(1);
      end
    end
  end

  wire line   = active ? sh[0] : 1'b1;
  wire shaped = lcr[0] ? 1'b0 : line;

  assign txd      = loopback ? 1'b1 : shaped;
  assign loop_txd = loopback ? shaped : 1'b1;
  assign tx_irq   = tx_irq_en && empty;
  assign flags    = {empty, 1'b0, full, 1'b0, busy, 3'b000};

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !load) |=> cnt == $past(cnt));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last));

  // R8
  cts_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(cts_ok && tick16));

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick16) |=> ($stable(sh) && active));
endmodule

// File: tb/uart_tx_cts_test.sv
module uart_tx_cts_test;
  logic clk = 0, rst_n = 0, tick16 = 0, cts_in = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] lcr = 7'b1110000;
  logic tx_irq_en = 0, loopback = 0, auto_flow = 0, cts_gate = 0, cts_pol = 0;
  logic txd, loop_txd, tx_irq;
  logic [7:0] flags;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";

  uart_tx_cts uut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .cts_in(cts_in),
    .wr_en(wr_en), .wr_data(wr_data), .lcr(lcr), .tx_irq_en(tx_irq_en),
    .loopback(loopback), .auto_flow(auto_flow), .cts_gate(cts_gate),
    .cts_pol(cts_pol), .txd(txd), .loop_txd(loop_txd), .tx_irq(tx_irq),
    .flags(flags));

  always #5 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  byte unsigned m_q[$];
  bit   m_act, try_ld, full_b, ok, p;
  int   m_bit, m_sub, m_n, cap, len, idx;
  bit   m_frame[12];
  byte unsigned d;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_act = 0; m_bit = 0; m_sub = 0; m_n = 0;
    end else begin
      cap = lcr[4] ? 16 : 1;
      full_b = m_q.size() >= cap;
      ok = !(auto_flow && cts_gate) || (cts_in == cts_pol);
      try_ld = 0;
      if (tick16) begin
        if (m_act) begin
          if (m_sub == 15) begin
            m_sub = 0;
            if (m_bit == m_n - 1) begin m_act = 0; try_ld = 1; end
            else m_bit++;
          end else m_sub++;
        end else try_ld = 1;
        if (try_ld && m_q.size() > 0 && ok) begin
          d = m_q.pop_front();
          len = 5 + int'(lcr[6:5]);
          p = !lcr[2];
          foreach (m_frame[k]) m_frame[k] = 1;
          m_frame[0] = 0;
          for (int k = 0; k < len; k++) begin
            m_frame[1+k] = d[k];
            p ^= d[k];
          end
          idx = 1 + len;
          if (lcr[1]) begin m_frame[idx] = p; idx++; end
          m_n = idx + 1 + int'(lcr[3]);
          m_act = 1; m_bit = 0; m_sub = 0;
        end
      end
      if (wr_en && !full_b) m_q.push_back(wr_data);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      bit e_line, e_sh, e_empty, e_full;
      e_line  = m_act ? m_frame[m_bit] : 1'b1;
      e_sh    = lcr[0] ? 1'b0 : e_line;
      e_empty = m_q.size() == 0;
      e_full  = m_q.size() >= (lcr[4] ? 16 : 1);
      chk(tag, txd, loopback ? 1 : e_sh);
      chk("R10", loop_txd, loopback ? e_sh : 1);
      chk("R6", flags, {e_empty, 1'b0, e_full, 1'b0, (m_act || !e_empty), 3'b000});
      chk("R9", tx_irq, tx_irq_en && e_empty);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic put(input byte unsigned b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic drain();
    while (m_act || m_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", txd, 1); chk("R1", loop_txd, 1);
    chk("R1", flags, 8'h80); chk("R1", tx_irq, 0);

    tag = "R2";
    put(8'hA5); put(8'h3C); drain();
    lcr = 7'b0110000; put(8'hC9); drain();

    tag = "R3";
    lcr = 7'b1010110; put(8'h55); put(8'h7F); drain();
    lcr = 7'b1110010; put(8'h01); put(8'h00); drain();

    tag = "R4";
    lcr = 7'b0011000; put(8'h1F); put(8'hE3); drain();
    lcr = 7'b1111110; put(8'h96); drain();

    tag = "R8";
    lcr = 7'b1110000;
    auto_flow = 1; cts_gate = 1; cts_pol = 0; cts_in = 1;
    for (int i = 0; i < 17; i++) put(8'(i * 13 + 1));
    repeat (40) @(negedge clk);
    chk("R6", flags[5], 1);
    chk("R8", txd, 1);
    cts_in = 0; drain();
    chk("R7", flags, 8'h80);

    put(8'h81); put(8'h42); put(8'h24);
    while (!(m_act && m_bit >= 4)) @(negedge clk);
    cts_in = 1;
    repeat (600) @(negedge clk);
    chk("R8", txd, 1);
    chk("R7", flags, 8'h08);
    cts_pol = 1; drain();
    cts_pol = 0; auto_flow = 0; put(8'h5A); drain();
    auto_flow = 1; cts_gate = 0; put(8'hA6); drain();
    auto_flow = 0; cts_in = 0;

    tag = "R6";
    lcr = 7'b1100000;
    put(8'h11);
    chk("R6", flags[5], 1);
    put(8'h22); drain();
    lcr = 7'b1110000;

    tag = "R5";
    put(8'hFF);
    repeat (100) @(negedge clk);
    lcr[0] = 1;
    repeat (50) @(negedge clk);
    chk("R5", txd, 0);
    lcr[0] = 0; drain();

    tag = "R10";
    loopback = 1; put(8'h0F);
    repeat (60) @(negedge clk);
    chk("R10", txd, 1);
    lcr[0] = 1; @(negedge clk);
    chk("R10", loop_txd, 0);
    lcr[0] = 0; drain(); loopback = 0;

    tag = "R9";
    tx_irq_en = 1; @(negedge clk);
    chk("R9", tx_irq, 1);
    put(8'h77);
    chk("R9", tx_irq, 0);
    drain();
    chk("R9", tx_irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule